// File: doc/BRIEF.md
# Receive Preamble and Start-of-Frame Delimiter Detector

This block sits at the very front of a receive MAC. It watches a byte-wide receive stream qualified by a data-valid strobe and searches for the frame header: a run of preamble bytes closed by the start-of-frame delimiter. A run-time configuration vector sets the first few preamble bytes. The remaining preamble bytes and the delimiter are fixed by parameters. Once the whole header has matched, the header is stripped and only the bytes behind it are passed downstream. The first of these bytes carries a start marker and the last carries an end marker.

A frame whose header does not match is dropped as a whole. The block then ignores the stream until data-valid falls. In half-duplex operation a collision indication blocks detection. A collision that arrives during the payload cuts the frame short and flags it as errored. In full-duplex operation the collision input has no effect. A receive-enable input gates the start of new frames.

Top module: `rx_hdr_sync`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `fr_valid`, `fr_sof`, `fr_eof` and `fr_err` are all 0.
- R2: A frame is accepted only if its first eight bytes are the header. Header byte i for i < PROG_BYTES (default 2) is `pre_cfg[8*i+7:8*i]`. Header bytes PROG_BYTES..6 are 0x55. Header byte 7 is 0xD5. Only the bytes after byte 7 are forwarded, in order, and the first of them carries `fr_sof`=1.
- R3: A payload byte taken at a clock edge is presented on `fr_data` with `fr_valid`=1 right after the edge that takes the next payload byte. The last byte is presented with `fr_eof`=1 right after the first edge at which `rx_dv` is sampled low. A one-byte frame shows `fr_sof` and `fr_eof` together.
- R4: If any header byte mismatches, the frame produces no output. The rest of the stream is then ignored until `rx_dv` is sampled low, even if it contains a valid header.
- R5: If `rx_dv` falls before the header completes, nothing is output, and a new search begins with the next `rx_dv` high.
- R6: `rx_en` is sampled only on the first byte of a frame. If it is low there, the whole frame is ignored, even if `rx_en` rises later in the frame.
- R7: With `full_duplex`=0, `rx_col` high on any header byte discards the frame.
- R8: With `full_duplex`=0, `rx_col` high on payload byte c (counted from 0) ends the frame. Bytes 0..c-1 are forwarded, and byte c-1 carries `fr_eof`=1 and `fr_err`=1. If c is 0, nothing is output. The rest of the stream is ignored until `rx_dv` falls.
- R9: With `full_duplex`=1, `rx_col` has no effect anywhere in a frame.
- R10: `fr_sof` and `fr_eof` are only ever high together with `fr_valid`, and `fr_err` only together with `fr_eof`. A frame with no bytes after the delimiter produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled on the first byte of a frame |
| full_duplex | input | 1 | 1 selects full duplex, in which the collision input is ignored |
| rx_dv | input | 1 | Receive data valid |
| rx_col | input | 1 | Collision indication |
| rxd | input | 8 | Receive byte |
| pre_cfg | input | 8*PROG_BYTES | Programmable leading preamble bytes, byte i in bits 8i+7:8i |
| fr_data | output | 8 | Forwarded frame byte |
| fr_valid | output | 1 | `fr_data` holds a frame byte |
| fr_sof | output | 1 | First byte of a frame |
| fr_eof | output | 1 | Last byte of a frame |
| fr_err | output | 1 | Frame ended by a collision |

## Verification
The header search is tried in several ways. Exact headers built from both the default and randomized programmable bytes show acceptance. Headers corrupted at a random position show rejection. A corrupt header followed by a perfect one in the same valid window separates a sticky drop from a search that restarts too early. Truncated headers, and headers with collisions in each duplex mode, separate the duplex gating from header matching. Payloads of zero, one and many bytes, with collisions placed at the first or a later byte, pin down the one-byte hold, the cycle of the end marker and the placement of the error flag. Timing checks tie the start and end markers to the exact edges at which the byte after them, and the fall of data-valid, are taken.

// File: rtl/rx_hdr_pkg.sv
package rx_hdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_FRAME = 2'd2,
    ST_DROP  = 2'd3
  } hdr_st_e;

  // Collision only matters when the link is half duplex.
  function automatic logic col_gate(input logic col, input logic fdx);
    return col & ~fdx;
  endfunction

  // A header position is matched when the byte equals the pattern byte.
  function automatic logic hdr_match(input logic [7:0] got, input logic [7:0] want);
    return got == want;
  endfunction

endpackage

// File: rtl/rx_hdr_pattern.sv
module rx_hdr_pattern #(
  parameter int unsigned PRE_LEN    = 7,
  parameter int unsigned PROG_BYTES = 2,
  parameter logic [7:0]  PRE_BYTE   = 8'h55,
  parameter logic [7:0]  SFD_BYTE   = 8'hD5
) (
  input  logic [PROG_BYTES*8-1:0]        pre_cfg,
  input  logic [$clog2(PRE_LEN+1)-1:0]   idx,
  input  logic [7:0]                     rxd,
  output logic                           byte_ok
);
  import rx_hdr_pkg::*;

  localparam int unsigned HDR_LEN = PRE_LEN + 1;

  logic [7:0] pat [HDR_LEN];

  // Header pattern: programmable bytes first, fixed preamble, then delimiter.
  for (genvar g = 0; g < PRE_LEN; g++) begin : g_pre
    if (g < PROG_BYTES) begin : g_prog
      assign pat[g] = pre_cfg[g*8 +: 8];
    end else begin : g_fixed
      assign pat[g] = PRE_BYTE;
    end
  end
  assign pat[PRE_LEN] = SFD_BYTE;

  assign byte_ok = hdr_match(rxd, pat[idx]);

endmodule

// File: rtl/rx_hdr_fsm.sv
module rx_hdr_fsm
  import rx_hdr_pkg::*;
#(
  parameter int unsigned HDR_LEN = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_dv,
  input  logic                        rx_en,
  input  logic                        rx_col,
  input  logic                        full_duplex,
  input  logic                        byte_ok,
  output hdr_st_e                     st,
  output logic [$clog2(HDR_LEN)-1:0]  idx,
  output logic                        data_take,
  output logic                        frame_end,
  output logic                        col_abort
);

  localparam int unsigned IDX_W = $clog2(HDR_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_LEN - 1);

  logic            col_block;
  hdr_st_e         st_n;
  logic [IDX_W-1:0] idx_n;

  assign col_block = col_gate(rx_col, full_duplex);

  always_comb begin
    st_n  = st;
    idx_n = idx;
    case (st)
      ST_IDLE: begin
        if (rx_dv) begin
          if (!rx_en || col_block || !byte_ok) begin
            st_n = ST_DROP;
          end else begin
            st_n  = ST_HDR;
            idx_n = IDX_W'(1);
          end
        end
      end
      ST_HDR: begin
        if (!rx_dv) begin
          st_n  = ST_IDLE;
          idx_n = '0;
        end else if (col_block || !byte_ok) begin
          st_n  = ST_DROP;
          idx_n = '0;
        end else if (idx == LAST_IDX) begin
          st_n  = ST_FRAME;
          idx_n = '0;
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      ST_FRAME: begin
        if (!rx_dv) begin
          st_n = ST_IDLE;
        end else if (col_block) begin
          st_n = ST_DROP;
        end
      end
      ST_DROP: begin
        if (!rx_dv) begin
          st_n = ST_IDLE;
        end
      end
      default: begin
        st_n  = ST_IDLE;
        idx_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
    end
  end

  assign data_take = (st == ST_FRAME) && rx_dv && !col_block;
  assign frame_end = (st == ST_FRAME) && !rx_dv;
  assign col_abort = (st == ST_FRAME) && rx_dv && col_block;

endmodule

// File: rtl/rx_hdr_outreg.sv
module rx_hdr_outreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rxd,
  input  logic       data_take,
  input  logic       frame_end,
  input  logic       col_abort,
  output logic [7:0] fr_data,
  output logic       fr_valid,
  output logic       fr_sof,
  output logic       fr_eof,
  output logic       fr_err
);

  logic       held_vld;
  logic       held_first;
  logic [7:0] held_byte;

  // One byte is held back so that the last byte can be tagged once data-valid falls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld   <= 1'b0;
      held_first <= 1'b0;
      held_byte  <= '0;
      fr_data    <= '0;
      fr_valid   <= 1'b0;
      fr_sof     <= 1'b0;
      fr_eof     <= 1'b0;
      fr_err     <= 1'b0;
    end else begin
      fr_valid <= 1'b0;
      fr_sof   <= 1'b0;
      fr_eof   <= 1'b0;
      fr_err   <= 1'b0;
      if (data_take) begin
        if (held_vld) begin
          fr_valid <= 1'b1;
          fr_sof   <= held_first;
          fr_data  <= held_byte;
        end
        held_byte  <= rxd;
        held_first <= !held_vld;
        held_vld   <= 1'b1;
      end else if (frame_end || col_abort) begin
        if (held_vld) begin
          fr_valid <= 1'b1;
          fr_sof   <= held_first;
          fr_eof   <= 1'b1;
          fr_err   <= col_abort;
          fr_data  <= held_byte;
        end
        held_vld   <= 1'b0;
        held_first <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_hdr_sync.sv
module rx_hdr_sync
  import rx_hdr_pkg::*;
#(
  parameter int unsigned PRE_LEN    = 7,
  parameter int unsigned PROG_BYTES = 2,
  parameter logic [7:0]  PRE_BYTE   = 8'h55,
  parameter logic [7:0]  SFD_BYTE   = 8'hD5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_en,
  input  logic                    full_duplex,
  input  logic                    rx_dv,
  input  logic                    rx_col,
  input  logic [7:0]              rxd,
  input  logic [PROG_BYTES*8-1:0] pre_cfg,
  output logic [7:0]              fr_data,
  output logic                    fr_valid,
  output logic                    fr_sof,
  output logic                    fr_eof,
  output logic                    fr_err
);

  localparam int unsigned HDR_LEN = PRE_LEN + 1;
  localparam int unsigned IDX_W   = $clog2(HDR_LEN);

  hdr_st_e          st;
  logic [IDX_W-1:0] idx;
  logic             byte_ok;
  logic             data_take;
  logic             frame_end;
  logic             col_abort;

  rx_hdr_pattern #(
    .PRE_LEN    (PRE_LEN),
    .PROG_BYTES (PROG_BYTES),
    .PRE_BYTE   (PRE_BYTE),
    .SFD_BYTE   (SFD_BYTE)
  ) u_pattern (
    .pre_cfg (pre_cfg),
    .idx     (idx),
    .rxd     (rxd),
    .byte_ok (byte_ok)
  );

  rx_hdr_fsm #(
    .HDR_LEN (HDR_LEN)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_dv       (rx_dv),
    .rx_en       (rx_en),
    .rx_col      (rx_col),
    .full_duplex (full_duplex),
    .byte_ok     (byte_ok),
    .st          (st),
    .idx         (idx),
    .data_take   (data_take),
    .frame_end   (frame_end),
    .col_abort   (col_abort)
  );

  rx_hdr_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .data_take (data_take),
    .frame_end (frame_end),
    .col_abort (col_abort),
    .fr_data   (fr_data),
    .fr_valid  (fr_valid),
    .fr_sof    (fr_sof),
    .fr_eof    (fr_eof),
    .fr_err    (fr_err)
  );

endmodule

// File: rtl/rx_hdr_sync_chk.sv
module rx_hdr_sync_chk
  import rx_hdr_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    rx_dv,
  input logic    rx_en,
  input logic    rx_col,
  input logic    full_duplex,
  input logic    fr_valid,
  input logic    fr_sof,
  input logic    fr_eof,
  input logic    fr_err,
  input hdr_st_e st,
  input logic    col_abort
);

  assert_sof_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fr_sof |-> fr_valid);

  assert_err_with_eof_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fr_err |-> (fr_eof && fr_valid));

  assert_output_only_from_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FRAME) |=> !fr_valid);

  assert_drop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP && rx_dv) |=> (st == ST_DROP));

  assert_start_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && rx_dv && !rx_en) |=> (st == ST_DROP));

  assert_hdr_col_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR && rx_dv && rx_col && !full_duplex) |=> (st == ST_DROP));

  assert_mid_col_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_abort |=> ((st == ST_DROP) && (!fr_valid || fr_err)));

  assert_fdx_col_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FRAME && rx_dv && full_duplex) |=> (st == ST_FRAME));

endmodule

bind rx_hdr_sync rx_hdr_sync_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_dv       (rx_dv),
  .rx_en       (rx_en),
  .rx_col      (rx_col),
  .full_duplex (full_duplex),
  .fr_valid    (fr_valid),
  .fr_sof      (fr_sof),
  .fr_eof      (fr_eof),
  .fr_err      (fr_err),
  .st          (st),
  .col_abort   (col_abort)
);

// File: tb/rx_hdr_sync_tb.sv
module rx_hdr_sync_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        full_duplex = 1'b0;
  logic        rx_dv = 1'b0;
  logic        rx_col = 1'b0;
  logic [7:0]  rxd = '0;
  logic [15:0] pre_cfg = 16'h5555;
  logic [7:0]  fr_data;
  logic        fr_valid, fr_sof, fr_eof, fr_err;

  int n_checks = 0;
  int n_errs = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [10:0] cap_q[$];
  int          cap_cyc[$];
  logic [10:0] exp_q[$];
  logic [7:0]  pay_q[$];

  rx_hdr_sync u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .full_duplex(full_duplex),
    .rx_dv(rx_dv), .rx_col(rx_col), .rxd(rxd), .pre_cfg(pre_cfg),
    .fr_data(fr_data), .fr_valid(fr_valid), .fr_sof(fr_sof),
    .fr_eof(fr_eof), .fr_err(fr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && fr_valid) begin
      cap_q.push_back({fr_sof, fr_eof, fr_err, fr_data});
      cap_cyc.push_back(cyc);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic dv, logic [7:0] d, logic c);
    @(posedge clk);
    #2;
    rx_dv  = dv;
    rxd    = d;
    rx_col = c;
  endtask

  function automatic logic [7:0] ref_hdr(int i, logic [15:0] cfg);
    if (i == 7) return 8'hD5;
    if (i < 2) return cfg[i*8 +: 8];
    return 8'h55;
  endfunction

  // bad: header byte to corrupt, hcol: header byte with collision,
  // trunc: header bytes sent before rx_dv falls (-1 = full), pcol: payload byte with collision
  task automatic run_frame(string req, logic en, logic fd, int bad, int hcol, int trunc, int pcol);
    int hlen;
    int n;
    int lim;
    int low_cyc;
    int first_cyc;
    bit ok;
    bit aborted;
    logic [7:0] b;
    cap_q.delete();
    cap_cyc.delete();
    exp_q.delete();
    full_duplex = fd;
    rx_en = en;
    hlen = (trunc >= 0) ? trunc : 8;
    first_cyc = 0;
    for (int i = 0; i < hlen; i++) begin
      b = ref_hdr(i, pre_cfg);
      if (i == bad) b = b ^ 8'h10;
      drive(1'b1, b, i == hcol);
      if (i == 1) rx_en = 1'b1;
    end
    n = (trunc >= 0) ? 0 : pay_q.size();
    for (int k = 0; k < n; k++) begin
      drive(1'b1, pay_q[k], k == pcol);
      if (k == 0) first_cyc = cyc;
    end
    drive(1'b0, 8'h00, 1'b0);
    low_cyc = cyc;
    for (int k = 0; k < 3; k++) drive(1'b0, 8'h00, 1'b0);

    ok = en && (bad < 0) && (trunc < 0) && !(hcol >= 0 && !fd);
    lim = (pcol >= 0 && !fd && pcol < n) ? pcol : n;
    aborted = (lim < n);
    if (ok) begin
      for (int k = 0; k < lim; k++)
        exp_q.push_back({k == 0, k == lim - 1, aborted && (k == lim - 1), pay_q[k]});
    end
    check(req, cap_q.size(), exp_q.size(), "byte count");
    for (int k = 0; k < cap_q.size() && k < exp_q.size(); k++)
      check(req, {21'd0, cap_q[k]}, {21'd0, exp_q[k]}, "sof/eof/err/data");
    if (exp_q.size() > 0 && cap_q.size() == exp_q.size() && !aborted) begin
      check("R3", cap_cyc[cap_q.size()-1], low_cyc + 1, "eof cycle");
      if (n >= 2) check("R3", cap_cyc[0], first_cyc + 2, "sof cycle");
    end
  endtask

  task automatic rand_payload(int n);
    pay_q.delete();
    for (int k = 0; k < n; k++) pay_q.push_back(8'($urandom));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {fr_valid, fr_sof, fr_eof, fr_err}, 4'b0, "outputs in reset");
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {fr_valid, fr_sof, fr_eof, fr_err}, 4'b0, "outputs after reset");

    // R2, R3: normal frame, default pattern
    rand_payload(5);
    run_frame("R2", 1, 0, -1, -1, -1, -1);
    // R3: single byte frame carries sof and eof
    rand_payload(1);
    run_frame("R3", 1, 0, -1, -1, -1, -1);
    // R10: empty frame
    pay_q.delete();
    run_frame("R10", 1, 0, -1, -1, -1, -1);
    // R4: corrupt first byte, then a perfect header inside the same window
    pay_q.delete();
    for (int i = 1; i < 8; i++) pay_q.push_back(ref_hdr(i, pre_cfg));
    for (int i = 0; i < 8; i++) pay_q.push_back(ref_hdr(i, pre_cfg));
    pay_q.push_back(8'hAB);
    pay_q.push_back(8'hCD);
    run_frame("R4", 1, 0, 0, -1, -1, -1);
    // R4: bad delimiter
    rand_payload(4);
    run_frame("R4", 1, 0, 7, -1, -1, -1);
    // R5: truncated header, then a good frame right after
    run_frame("R5", 1, 0, -1, -1, 4, -1);
    rand_payload(3);
    run_frame("R5", 1, 0, -1, -1, -1, -1);
    // R6: disabled on first byte, enabled later in frame
    rand_payload(4);
    run_frame("R6", 0, 0, -1, -1, -1, -1);
    // R7: collision in header, half duplex
    rand_payload(4);
    run_frame("R7", 1, 0, -1, 3, -1, -1);
    // R8: collision mid payload and on first payload byte
    rand_payload(6);
    run_frame("R8", 1, 0, -1, -1, -1, 3);
    rand_payload(6);
    run_frame("R8", 1, 0, -1, -1, -1, 0);
    // R9: full duplex ignores collision in header and payload
    rand_payload(6);
    run_frame("R9", 1, 1, -1, 2, -1, -1);
    rand_payload(6);
    run_frame("R9", 1, 1, -1, -1, -1, 2);
    // R2: programmable bytes
    pre_cfg = 16'hA73C;
    rand_payload(4);
    run_frame("R2", 1, 0, -1, -1, -1, -1);
    rand_payload(4);
    pay_q.delete();
    pay_q.push_back(8'h11);
    pre_cfg = 16'h5555;
    // default header while configuration differs must be rejected
    cap_q.delete();
    exp_q.delete();
    rx_en = 1'b1;
    full_duplex = 1'b0;
    #1;
    pre_cfg = 16'h1234;
    for (int i = 0; i < 8; i++) drive(1'b1, (i == 7) ? 8'hD5 : 8'h55, 1'b0);
    drive(1'b1, 8'h77, 1'b0);
    drive(1'b1, 8'h78, 1'b0);
    for (int k = 0; k < 4; k++) drive(1'b0, 8'h00, 1'b0);
    check("R2", cap_q.size(), 0, "mismatched programmable bytes");

    // constrained random mix
    for (int it = 0; it < 200; it++) begin
      int sel;
      int n;
      logic fd;
      if (($urandom % 4) == 0) pre_cfg = 16'($urandom);
      n = $urandom % 12;
      fd = 1'($urandom);
      rand_payload(n);
      sel = $urandom % 8;
      case (sel)
        0: run_frame("R4", 1, fd, $urandom % 8, -1, -1, -1);
        1: run_frame("R5", 1, fd, -1, -1, 1 + ($urandom % 7), -1);
        2: run_frame("R7", 1, fd, -1, $urandom % 8, -1, -1);
        3: run_frame("R8", 1, fd, -1, -1, -1, (n > 0) ? ($urandom % n) : 0);
        4: run_frame("R6", 0, fd, -1, -1, -1, -1);
        default: run_frame("R2", 1, fd, -1, -1, -1, -1);
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule